// File: doc/BRIEF.md
# Short-Circuit Shutdown Timer for Twelve Power Switches

This block watches the twelve power switches of six half-bridges (a high-side and a low-side switch per bridge) for sustained overcurrent. Each switch reports, through its own flag, that its current limiter is active. For every switch that stays in current limit, a dedicated counter advances on a slow time-base tick. When that counter reaches the selected shutdown delay, the switch is latched off and a shared short-detected flag is raised. One select input chooses between a short delay and a long delay, about eight times as long. The tick counts for the two delays are parameters.

A thermal prewarning input speeds up the shutdown. While the prewarning is active, any switch that is in overcurrent is latched off in the next cycle, without waiting for its timer. A switch that has been latched off stays off, and its timer stays idle, until a status-reset pulse arrives. Removing the fault does not release it. The reset pulse clears the short flag and releases every latched switch. If a switch expires in the same cycle as a reset, the expiry takes precedence. The surrounding logic combines the disable mask with the commanded gate states, so that any switch whose mask bit is set is held off.

Top module: `short_guard`

## Requirements
- R1: During and after a synchronous active-low reset, `off_mask_o` is all zeros and `short_o` is 0.
- R2: With `long_dly_i` = 0, a switch whose overcurrent bit i stays at 1 for SHORT_TICKS tick cycles has `off_mask_o[i]` set, and `short_o` set, one clock after the cycle that carries its SHORT_TICKS-th tick. No other mask bit changes.
- R3: With `long_dly_i` = 1, the delay is LONG_TICKS ticks. After SHORT_TICKS ticks the mask bit is still 0.
- R4: If overcurrent bit i goes to 0 in any cycle before expiry, the timer of switch i returns to zero. A later overcurrent then needs a full delay again.
- R5: If `warn_i` = 1 and overcurrent bit i = 1 in the same cycle, `off_mask_o[i]` and `short_o` are 1 after the next clock edge, whether or not a tick is present.
- R6: A set mask bit stays set after its overcurrent clears, until `clr_i` is pulsed. While the bit is set, its timer stays at zero.
- R7: A cycle with `clr_i` = 1 and no expiry clears `short_o` and every mask bit after that clock edge.
- R8: When an expiry and `clr_i` fall in the same cycle, the expiring switch's mask bit and `short_o` are 1 after that edge.
- R9: Timers advance only in cycles with `tick_i` = 1. Cycles without a tick change no timer.
- R10: `warn_i` = 1 with no overcurrent has no effect on the outputs.
- R11: The timers run independently per switch. Each switch latches at its own expiry, and an interruption on one switch does not affect another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovc_i | input | 12 | Overcurrent flag per switch; bit i belongs to switch i |
| long_dly_i | input | 1 | Delay select: 0 = SHORT_TICKS, 1 = LONG_TICKS |
| warn_i | input | 1 | Thermal prewarning active |
| clr_i | input | 1 | Status-reset pulse, one cycle |
| tick_i | input | 1 | Single-cycle time-base tick |
| off_mask_o | output | 12 | Bit i = 1: switch i latched off |
| short_o | output | 1 | Short-detected flag |

## Verification
A timer that miscounts shows up as a mask bit that rises one or more ticks too early or too late. The bench samples every cycle of the tick sequence, so such an error is seen within one cycle of the expected expiry. A timer that fails to clear on an interruption, or that keeps running while its switch is latched, shows up as an early latch on the next fault episode of that switch. A wrong latch or flag priority shows up in the first cycle after the reset or prewarning stimulus, as a mask bit or short flag with the wrong value.

// File: rtl/short_guard_pkg.sv
// Package: shared constants for the short-circuit shutdown timer.
package short_guard_pkg;
    localparam int unsigned SW_COUNT      = 12;  // six bridges, two switches each
    localparam int unsigned DEF_SHORT_TCK = 3;   // default short delay, ticks
    localparam int unsigned DEF_LONG_TCK  = 24;  // default long delay, ticks
endpackage

// File: rtl/sg_delay_pick.sv
// Module: sg_delay_pick
// Selects the active shutdown limit in ticks from the delay-select bit.
// Assumes: both limits are at least 1 and fit in CW bits.
module sg_delay_pick #(
    parameter int unsigned SHORT_TICKS = 3,
    parameter int unsigned LONG_TICKS  = 24,
    parameter int unsigned CW          = 5
) (
    input  logic          long_dly_i,
    output logic [CW-1:0] limit_o
);
    localparam logic [CW-1:0] LIM_S = CW'(SHORT_TICKS);
    localparam logic [CW-1:0] LIM_L = CW'(LONG_TICKS);

    // Purpose: choose the limit for the selected delay
    always_comb begin
        limit_o = long_dly_i ? LIM_L : LIM_S;
    end
endmodule

// File: rtl/sg_switch_timer.sv
// Module: sg_switch_timer
// Runs the overcurrent timer of one switch and holds its latch-off state.
// Assumes: tick_i and clr_i are single-cycle pulses; limit_i >= 1.
module sg_switch_timer #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ovc_i,
    input  logic          warn_i,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o,
    output logic          off_o
);
    logic [CW-1:0] cnt_q;
    logic          latched_q;
    logic [CW:0]   cnt_inc;
    logic          hit;

    // Purpose: detect the tick on which the count reaches the limit
    always_comb begin
        cnt_inc  = {1'b0, cnt_q} + 1'b1;
        hit      = ovc_i && tick_i && !latched_q && (cnt_inc >= {1'b0, limit_i});
        expire_o = ovc_i && (warn_i || hit);
    end

    // Purpose: advance the timer during an unbroken overcurrent, else hold it at zero
    always_ff @(posedge clk) begin
        if (!rst_n || !ovc_i || latched_q || expire_o)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= cnt_inc[CW-1:0];
    end

    // Purpose: latch the switch off on expiry; the reset pulse releases it, and expiry wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            latched_q <= 1'b0;
        else if (expire_o)
            latched_q <= 1'b1;
        else if (clr_i)
            latched_q <= 1'b0;
    end

    assign off_o = latched_q;

    // R5
    warn_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovc_i && warn_i) |=> latched_q);
    // R4
    drop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovc_i |=> (cnt_q == '0));
    // R6
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_q && !clr_i) |=> (latched_q && cnt_q == '0));
    // R9
    no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !warn_i && !clr_i && ovc_i && !latched_q) |=> ($stable(cnt_q) && !latched_q));
    // R2
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched_q) |-> $past(ovc_i));
endmodule

// File: rtl/short_guard.sv
// Module: short_guard
// Short-circuit shutdown supervisor for twelve half-bridge switches: one
// timer per switch, a shared delay select, and a common short flag.
// Assumes: ovc_i is synchronous to clk; the user holds a switch off when its mask bit is set.
module short_guard
    import short_guard_pkg::*;
#(
    parameter int unsigned NSW         = SW_COUNT,
    parameter int unsigned SHORT_TICKS = DEF_SHORT_TCK,
    parameter int unsigned LONG_TICKS  = DEF_LONG_TCK
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NSW-1:0] ovc_i,
    input  logic           long_dly_i,
    input  logic           warn_i,
    input  logic           clr_i,
    input  logic           tick_i,
    output logic [NSW-1:0] off_mask_o,
    output logic           short_o
);
    localparam int unsigned MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int unsigned CW   = $clog2(MAXT + 1);

    logic [CW-1:0]  limit;
    logic [NSW-1:0] expire;
    logic           short_q;

    sg_delay_pick #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS),
        .CW          (CW)
    ) u_pick (
        .long_dly_i (long_dly_i),
        .limit_o    (limit)
    );

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        sg_switch_timer #(.CW(CW)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .ovc_i    (ovc_i[i]),
            .warn_i   (warn_i),
            .clr_i    (clr_i),
            .tick_i   (tick_i),
            .limit_i  (limit),
            .expire_o (expire[i]),
            .off_o    (off_mask_o[i])
        );
    end

    // Purpose: set the shared short flag on any expiry; the reset pulse clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            short_q <= 1'b0;
        else if (|expire)
            short_q <= 1'b1;
        else if (clr_i)
            short_q <= 1'b0;
    end

    assign short_o = short_q;

    // R2
    flag_with_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((off_mask_o & ~$past(off_mask_o)) != '0) |-> short_o);
    // R7
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && ovc_i == '0) |=> (off_mask_o == '0 && !short_o));
    // R10
    warn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovc_i == '0 && !clr_i) |=> $stable(off_mask_o));
endmodule

// File: tb/short_guard_test.sv
module short_guard_test;
    localparam int unsigned NSW = 12;
    localparam int unsigned ST  = 3;
    localparam int unsigned LT  = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSW-1:0]  ovc_i = '0;
    logic            long_dly_i = 1'b0, warn_i = 1'b0, clr_i = 1'b0, tick_i = 1'b0;
    logic [NSW-1:0]  off_mask_o;
    logic            short_o;
    int              checks = 0;
    int              errors = 0;
    bit              done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    short_guard #(.NSW(NSW), .SHORT_TICKS(ST), .LONG_TICKS(LT)) uut (
        .clk(clk), .rst_n(rst_n), .ovc_i(ovc_i), .long_dly_i(long_dly_i),
        .warn_i(warn_i), .clr_i(clr_i), .tick_i(tick_i),
        .off_mask_o(off_mask_o), .short_o(short_o)
    );

    // vector: ovc, sel, warn, clr, tick, expected mask, expected short
    localparam int NV = 26;
    localparam logic [28:0] VEC [NV] = '{
        {12'h001,1'b0,1'b0,1'b0,1'b1, 12'h000,1'b0},  // 0  R2 tick1
        {12'h001,1'b0,1'b0,1'b0,1'b0, 12'h000,1'b0},  // 1  R9 no tick
        {12'h001,1'b0,1'b0,1'b0,1'b1, 12'h000,1'b0},  // 2  R2 tick2
        {12'h001,1'b0,1'b0,1'b0,1'b1, 12'h001,1'b1},  // 3  R2 expiry
        {12'h000,1'b0,1'b0,1'b0,1'b1, 12'h001,1'b1},  // 4  R6 held
        {12'h000,1'b0,1'b0,1'b1,1'b0, 12'h000,1'b0},  // 5  R7 clear
        {12'h002,1'b0,1'b0,1'b0,1'b1, 12'h000,1'b0},  // 6  R4
        {12'h002,1'b0,1'b0,1'b0,1'b1, 12'h000,1'b0},  // 7  R4
        {12'h000,1'b0,1'b0,1'b0,1'b1, 12'h000,1'b0},  // 8  R4 drop
        {12'h002,1'b0,1'b0,1'b0,1'b1, 12'h000,1'b0},  // 9  R4 restart
        {12'h002,1'b0,1'b0,1'b0,1'b1, 12'h000,1'b0},  // 10 R4
        {12'h002,1'b0,1'b0,1'b0,1'b1, 12'h002,1'b1},  // 11 R4 full delay
        {12'h000,1'b0,1'b0,1'b1,1'b0, 12'h000,1'b0},  // 12 R7
        {12'h000,1'b0,1'b1,1'b0,1'b1, 12'h000,1'b0},  // 13 R10
        {12'h800,1'b0,1'b1,1'b0,1'b0, 12'h800,1'b1},  // 14 R5
        {12'h800,1'b0,1'b0,1'b1,1'b0, 12'h000,1'b0},  // 15 R7 release
        {12'h800,1'b0,1'b0,1'b0,1'b1, 12'h000,1'b0},  // 16 R6 timer was idle
        {12'h800,1'b0,1'b0,1'b0,1'b1, 12'h000,1'b0},  // 17
        {12'h800,1'b0,1'b0,1'b1,1'b1, 12'h800,1'b1},  // 18 R8
        {12'h000,1'b0,1'b0,1'b1,1'b0, 12'h000,1'b0},  // 19
        {12'h030,1'b0,1'b0,1'b0,1'b1, 12'h000,1'b0},  // 20 R11
        {12'h010,1'b0,1'b0,1'b0,1'b1, 12'h000,1'b0},  // 21 R11
        {12'h030,1'b0,1'b0,1'b0,1'b1, 12'h010,1'b1},  // 22 R11
        {12'h030,1'b0,1'b0,1'b0,1'b1, 12'h010,1'b1},  // 23 R11
        {12'h030,1'b0,1'b0,1'b0,1'b1, 12'h030,1'b1},  // 24 R11
        {12'h000,1'b0,1'b0,1'b1,1'b0, 12'h000,1'b0}   // 25 R7
    };

    task automatic check(input string req, input logic [NSW-1:0] em, input logic es);
        checks++;
        if (off_mask_o !== em || short_o !== es) begin
            errors++;
            $display("FAIL %s: mask=%h short=%b expected mask=%h short=%b",
                     req, off_mask_o, short_o, em, es);
        end
    endtask

    // one cycle: drive at the falling edge, sample just after the next rising edge
    task automatic step(input logic [NSW-1:0] o, input logic s, input logic w,
                        input logic c, input logic t);
        @(negedge clk);
        ovc_i = o; long_dly_i = s; warn_i = w; clr_i = c; tick_i = t;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 during reset", 12'h000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step('0, 0, 0, 0, 0);
        check("R1 after reset", 12'h000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][28:17], VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13]);
            check($sformatf("vector %0d", i), VEC[i][12:1], VEC[i][0]);
        end

        // R3: long delay select
        for (int k = 1; k < int'(LT); k++) begin
            step(12'h004, 1, 0, 0, 1);
            if (k == int'(ST)) check("R3 short count passed", 12'h000, 1'b0);
        end
        check("R3 one tick before long expiry", 12'h000, 1'b0);
        step(12'h004, 1, 0, 0, 1);
        check("R3 long expiry", 12'h004, 1'b1);

        // R1: reset clears a latched state
        @(negedge clk);
        rst_n = 1'b0; ovc_i = '0; tick_i = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset clears latch", 12'h000, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: mask=%h short=%b expected completion", off_mask_o, short_o);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule